// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a local oscillator runs close enough to a target frequency to count as locked. Both frequencies reach it as single-cycle tick pulses synchronous to one system clock. The block counts oscillator ticks over a window of 2^WIN_LOG2 target ticks and compares the count with the nominal count, 2^(WIN_LOG2+RATIO_LOG2). It then updates a loss-of-lock flag. The flag uses a wide threshold to assert and a narrow threshold to release. Errors that fall between the two thresholds leave the flag unchanged.

A sticky bit records that lock was lost at some point since it was last cleared. A configuration input chooses whether the output pin shows the live flag or the sticky bit. There are two level-style control inputs. Each one acts only when it drops from 1 back to 0. One clears the sticky bit. The other forces a fresh acquisition.

The ppm thresholds become whole tick counts at elaboration: floor(nominal × ppm / 10^6). The block therefore needs no divider. The designer chooses WIN_LOG2 so that one window plus a few cycles fits inside the required response time of the flag.

Top module: `freq_lock_det`

## Requirements
- R1: After reset, lol_live is 1, lol_sticky is 0, meas_valid is 0, and lol_pin shows lol_live.
- R2: meas_valid pulses for exactly one cycle, in the cycle after the clock edge that samples the 2^WIN_LOG2-th target tick of a window. In that cycle, meas_err equals the oscillator ticks in the window minus the nominal count. An oscillator tick in the same cycle as that last target tick belongs to the window.
- R3: When a measurement has an error magnitude strictly greater than the assert threshold, lol_live is 1 in the cycle after meas_valid.
- R4: When a measurement has an error magnitude at or below the release threshold, lol_live is 0 in the cycle after meas_valid. A magnitude between the two thresholds leaves lol_live unchanged.
- R5: lol_sticky goes to 1 whenever a measurement moves lol_live from 0 to 1. It stays 1 when lock returns.
- R6: lol_sticky is cleared only in the cycle after ctl_sticky_clr goes from 1 to 0. Holding ctl_sticky_clr at 1 has no effect.
- R7: lol_pin equals lol_sticky when cfg_pin_sticky is 1, and equals lol_live when cfg_pin_sticky is 0.
- R8: In the cycle after ctl_restart goes from 1 to 0, lol_live is 1 and the window counters restart from zero. lol_sticky and the configuration are left untouched, and this forced acquisition does not set lol_sticky. Holding ctl_restart at 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | One-cycle pulse per target-frequency period |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| cfg_pin_sticky | input | 1 | 1: pin shows the sticky bit; 0: pin shows live status |
| ctl_sticky_clr | input | 1 | Write 1 then 0 to clear the sticky bit |
| ctl_restart | input | 1 | Write 1 then 0 to force a new acquisition |
| lol_pin | output | 1 | Loss-of-lock pin, active high |
| lol_live | output | 1 | Live loss-of-lock status |
| lol_sticky | output | 1 | Sticky loss-of-lock status |
| meas_valid | output | 1 | One-cycle strobe when a window completes |
| meas_err | output | WIN_LOG2+RATIO_LOG2+3 | Signed tick-count error of the last window |

## Verification
The bench builds the block with WIN_LOG2=10 and RATIO_LOG2=2. This gives a nominal count of 4096, an assert threshold of 4 ticks and a release threshold of 1 tick. Each window lasts 8192 clocks. With these values, the bench can place window errors of 5, 4, 2, 1 and 0 ticks, of both signs, exactly on either side of each threshold. It runs a dozen windows, covering both hysteresis edges, sticky clearing and a restart in the middle of a window.

// File: rtl/flk_pkg.sv
package flk_pkg;

    typedef enum logic {
        ST_LOCKED  = 1'b0,
        ST_ACQUIRE = 1'b1
    } lock_st_e;

    // Whole-tick threshold for a ppm limit over a nominal count of 2^nom_log2
    function automatic longint ppm_to_count(input int nom_log2, input int ppm);
        longint nom;
        nom = longint'(1) << nom_log2;
        return (nom * longint'(ppm)) / longint'(1000000);
    endfunction

endpackage

// File: rtl/flk_fall.sv
module flk_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end

    assign fall = seen_q & ~lvl;

endmodule

// File: rtl/flk_window.sv
module flk_window #(
    parameter int WIN_LOG2   = 14,
    parameter int RATIO_LOG2 = 6,
    parameter int CNT_W      = WIN_LOG2 + RATIO_LOG2 + 2,
    parameter int ERR_W      = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             osc_tick,
    input  logic             restart_fall,
    output logic             win_valid,
    output logic [ERR_W-1:0] win_err
);
    localparam logic [ERR_W-1:0] NOM_CNT = ERR_W'(longint'(1) << (WIN_LOG2 + RATIO_LOG2));
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [WIN_LOG2-1:0] REF_LAST = {WIN_LOG2{1'b1}};

    typedef struct packed {
        logic [WIN_LOG2-1:0] ref_cnt;
        logic [CNT_W-1:0]    osc_cnt;
        logic                valid;
        logic [ERR_W-1:0]    err;
    } win_t;

    win_t st_d, st_q;
    logic [CNT_W-1:0] osc_sum;
    logic             last_ref;

    always_comb begin
        st_d     = st_q;
        osc_sum  = st_q.osc_cnt;
        if (osc_tick && (st_q.osc_cnt != CNT_MAX)) osc_sum = st_q.osc_cnt + CNT_W'(1);
        last_ref = ref_tick && (st_q.ref_cnt == REF_LAST);
        if (restart_fall) begin
            st_d.ref_cnt = '0;
            st_d.osc_cnt = '0;
            st_d.valid   = 1'b0;
        end else if (last_ref) begin
            st_d.ref_cnt = '0;
            st_d.osc_cnt = '0;
            st_d.valid   = 1'b1;
            st_d.err     = {1'b0, osc_sum} - NOM_CNT;
        end else begin
            st_d.ref_cnt = st_q.ref_cnt + WIN_LOG2'(ref_tick);
            st_d.osc_cnt = osc_sum;
            st_d.valid   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_valid = st_q.valid;
    assign win_err   = st_q.err;

    // R2: a completed window is reported by a single-cycle strobe
    a_r2_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> !win_valid);

    // R8: a restart discards the window in progress
    a_r8_restart_window: assert property (@(posedge clk) disable iff (!rst_n)
        restart_fall |=> (!win_valid && st_q.ref_cnt == '0));

endmodule

// File: rtl/flk_hyst.sv
module flk_hyst #(
    parameter int     ERR_W       = 23,
    parameter longint THR_ASSERT  = 1048,
    parameter longint THR_RELEASE = 262
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid,
    input  logic [ERR_W-1:0] win_err,
    input  logic             restart_fall,
    input  logic             clr_fall,
    input  logic             cfg_pin_sticky,
    output logic             lol_live,
    output logic             lol_sticky,
    output logic             lol_pin
);
    import flk_pkg::*;

    localparam logic [ERR_W-1:0] LIM_A = ERR_W'(THR_ASSERT);
    localparam logic [ERR_W-1:0] LIM_R = ERR_W'(THR_RELEASE);

    typedef struct packed {
        lock_st_e st;
        logic     sticky;
    } hyst_t;

    hyst_t st_d, st_q;
    logic [ERR_W-1:0] mag;
    logic             loss_evt;

    always_comb begin
        st_d     = st_q;
        loss_evt = 1'b0;
        mag      = win_err[ERR_W-1] ? (~win_err + ERR_W'(1)) : win_err;
        if (restart_fall) begin
            st_d.st = ST_ACQUIRE;
        end else if (win_valid) begin
            if (mag > LIM_A) begin
                st_d.st  = ST_ACQUIRE;
                loss_evt = (st_q.st == ST_LOCKED);
            end else if (mag <= LIM_R) begin
                st_d.st = ST_LOCKED;
            end
        end
        st_d.sticky = loss_evt | (st_q.sticky & ~clr_fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st     <= ST_ACQUIRE;
            st_q.sticky <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lol_live   = (st_q.st == ST_ACQUIRE);
    assign lol_sticky = st_q.sticky;
    assign lol_pin    = cfg_pin_sticky ? lol_sticky : lol_live;

    // R3: the flag only rises after a measurement or a restart
    a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lol_live) |-> ($past(win_valid) || $past(restart_fall)));

    // R4: the flag only falls after a measurement without a restart
    a_r4_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lol_live) |-> ($past(win_valid) && !$past(restart_fall)));

    // R5: a measured loss always leaves the sticky bit set
    a_r5_loss_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lol_live) && !$past(restart_fall)) |-> lol_sticky);

    // R5: without a clear, the sticky bit holds
    a_r5_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (lol_sticky && !clr_fall) |=> lol_sticky);

    // R6: a clear with no measurement pending empties the sticky bit
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fall && !win_valid) |=> !lol_sticky);

    // R8: a restart always enters acquisition
    a_r8_restart_acq: assert property (@(posedge clk) disable iff (!rst_n)
        restart_fall |=> lol_live);

endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det #(
    parameter int WIN_LOG2     = 14,
    parameter int RATIO_LOG2   = 6,
    parameter int ASSERT_PPM   = 1000,
    parameter int RELEASE_PPM  = 250,
    localparam int ERR_W       = WIN_LOG2 + RATIO_LOG2 + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_tick,
    input  logic                    osc_tick,
    input  logic                    cfg_pin_sticky,
    input  logic                    ctl_sticky_clr,
    input  logic                    ctl_restart,
    output logic                    lol_pin,
    output logic                    lol_live,
    output logic                    lol_sticky,
    output logic                    meas_valid,
    output logic signed [ERR_W-1:0] meas_err
);
    localparam int     CNT_W  = ERR_W - 1;
    localparam longint THR_A  = flk_pkg::ppm_to_count(WIN_LOG2 + RATIO_LOG2, ASSERT_PPM);
    localparam longint THR_R  = flk_pkg::ppm_to_count(WIN_LOG2 + RATIO_LOG2, RELEASE_PPM);

    logic             clr_fall;
    logic             restart_fall;
    logic             win_valid;
    logic [ERR_W-1:0] win_err;

    flk_fall u_clr_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ctl_sticky_clr),
        .fall  (clr_fall)
    );

    flk_fall u_restart_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ctl_restart),
        .fall  (restart_fall)
    );

    flk_window #(
        .WIN_LOG2   (WIN_LOG2),
        .RATIO_LOG2 (RATIO_LOG2),
        .CNT_W      (CNT_W),
        .ERR_W      (ERR_W)
    ) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_tick     (ref_tick),
        .osc_tick     (osc_tick),
        .restart_fall (restart_fall),
        .win_valid    (win_valid),
        .win_err      (win_err)
    );

    flk_hyst #(
        .ERR_W       (ERR_W),
        .THR_ASSERT  (THR_A),
        .THR_RELEASE (THR_R)
    ) u_hyst (
        .clk            (clk),
        .rst_n          (rst_n),
        .win_valid      (win_valid),
        .win_err        (win_err),
        .restart_fall   (restart_fall),
        .clr_fall       (clr_fall),
        .cfg_pin_sticky (cfg_pin_sticky),
        .lol_live       (lol_live),
        .lol_sticky     (lol_sticky),
        .lol_pin        (lol_pin)
    );

    assign meas_valid = win_valid;
    assign meas_err   = $signed(win_err);

    // R1: out of reset, acquisition with the sticky bit clear
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (lol_live && !lol_sticky && !meas_valid));

endmodule

// File: tb/freq_lock_det_tb.sv
module freq_lock_det_tb;
    localparam int WL    = 10;
    localparam int RL    = 2;
    localparam int EW    = WL + RL + 3;
    localparam int WIN   = 1 << WL;
    localparam int NOM   = 1 << (WL + RL);
    localparam int THA   = (NOM * 1000) / 1000000;
    localparam int THD   = (NOM * 250) / 1000000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_tick = 1'b0, osc_tick = 1'b0;
    logic cfg = 1'b0, clr = 1'b0, rs = 1'b0;
    logic lol_pin, lol_live, lol_sticky, meas_valid;
    logic signed [EW-1:0] meas_err;

    freq_lock_det #(.WIN_LOG2(WL), .RATIO_LOG2(RL)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .osc_tick(osc_tick),
        .cfg_pin_sticky(cfg), .ctl_sticky_clr(clr), .ctl_restart(rs),
        .lol_pin(lol_pin), .lol_live(lol_live), .lol_sticky(lol_sticky),
        .meas_valid(meas_valid), .meas_err(meas_err)
    );

    always #2 clk = ~clk;

    int total = 0, bad = 0;
    bit n_cfg = 0, n_clr = 0, n_rs = 0;
    int m_ref = 0, m_osc = 0, m_err = 0, last_err = 0;
    bit m_valid = 0, m_lol = 1, m_sticky = 0, m_clrp = 0, m_rsp = 0;

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input bit r, input bit o);
        bit cf, rf, nl;
        int mag;
        @(negedge clk);
        chk("R3 R4 lol_live", int'(lol_live), int'(m_lol));
        chk("R5 R6 lol_sticky", int'(lol_sticky), int'(m_sticky));
        chk("R7 lol_pin", int'(lol_pin), int'(cfg ? m_sticky : m_lol));
        chk("R2 meas_valid", int'(meas_valid), int'(m_valid));
        if (m_valid) begin
            chk("R2 meas_err", int'(meas_err), m_err);
            last_err = int'(meas_err);
        end
        ref_tick = r; osc_tick = o; cfg = n_cfg; clr = n_clr; rs = n_rs;
        cf = m_clrp && !clr;
        rf = m_rsp && !rs;
        nl = m_lol;
        if (rf) nl = 1;
        else if (m_valid) begin
            mag = (m_err < 0) ? -m_err : m_err;
            if (mag > THA) nl = 1;
            else if (mag <= THD) nl = 0;
        end
        m_sticky = (!rf && m_valid && !m_lol && nl) || (m_sticky && !cf);
        m_lol = nl;
        if (rf) begin
            m_ref = 0; m_osc = 0; m_valid = 0;
        end else if (r && m_ref == WIN - 1) begin
            m_err = m_osc + int'(o) - NOM; m_valid = 1; m_ref = 0; m_osc = 0;
        end else begin
            m_ref += int'(r); m_osc += int'(o); m_valid = 0;
        end
        m_clrp = clr; m_rsp = rs;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    // Each target period is 8 clocks with nominally 4 oscillator ticks;
    // the first |delta| periods carry one tick more or less.
    task automatic run_periods(input int delta, input int periods);
        int ad;
        ad = (delta < 0) ? -delta : delta;
        for (int p = 0; p < periods; p++) begin
            int n;
            n = 4 + ((p < ad) ? ((delta < 0) ? -1 : 1) : 0);
            for (int c = 0; c < 8; c++)
                step(c == 7, (c == 0) || (c == 2) || (c == 4) ||
                             (c == 6 && n >= 4) || (c == 1 && n == 5));
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk("R1 lol_live", int'(lol_live), 1);
        chk("R1 lol_sticky", int'(lol_sticky), 0);
        chk("R1 meas_valid", int'(meas_valid), 0);
        chk("R1 lol_pin", int'(lol_pin), 1);
        idle(2);

        run_periods(0, WIN); idle(3);
        chk("R2 err zero", last_err, 0);
        chk("R4 release at 0", int'(lol_live), 0);
        chk("R5 no event", int'(lol_sticky), 0);

        run_periods(4, WIN); idle(3);
        chk("R2 err +4", last_err, 4);
        chk("R4 hold at +4", int'(lol_live), 0);

        run_periods(-4, WIN); idle(3);
        chk("R2 err -4", last_err, -4);
        chk("R4 hold at -4", int'(lol_live), 0);

        run_periods(5, WIN); idle(3);
        chk("R3 assert at +5", int'(lol_live), 1);
        chk("R5 sticky set", int'(lol_sticky), 1);

        run_periods(2, WIN); idle(3);
        chk("R4 hold high at +2", int'(lol_live), 1);

        run_periods(-1, WIN); idle(3);
        chk("R4 release at -1", int'(lol_live), 0);
        chk("R5 sticky kept", int'(lol_sticky), 1);

        n_cfg = 1; idle(2);
        chk("R7 pin shows sticky", int'(lol_pin), 1);
        n_clr = 1; idle(4);
        chk("R6 level ignored", int'(lol_sticky), 1);
        n_clr = 0; idle(2);
        chk("R6 cleared", int'(lol_sticky), 0);
        chk("R7 pin after clear", int'(lol_pin), 0);

        run_periods(-6, WIN); idle(3);
        chk("R3 assert at -6", int'(lol_live), 1);
        chk("R5 sticky again", int'(lol_sticky), 1);
        chk("R7 pin high", int'(lol_pin), 1);

        run_periods(0, WIN); idle(3);
        chk("R4 relock", int'(lol_live), 0);
        chk("R7 pin sticky while locked", int'(lol_pin), 1);

        n_cfg = 0;
        run_periods(0, 500);
        n_rs = 1; idle(3);
        chk("R8 level ignored", int'(lol_live), 0);
        n_rs = 0; idle(2);
        chk("R8 forced acquisition", int'(lol_live), 1);
        chk("R8 sticky untouched", int'(lol_sticky), 1);
        chk("R8 config kept", int'(lol_pin), 1);

        run_periods(0, WIN); idle(3);
        chk("R8 window restarted", last_err, 0);
        chk("R8 relock after restart", int'(lol_live), 0);

        finish_run();
    end

endmodule